// File: doc/BRIEF.md
# Sticky Host Bus Mode Detector

This block decides which of four host-interface personalities a device takes on. It watches two board-level pins. One is a strobe/clock pin that either sits at a fixed level or toggles. The other is a strap pin. A fixed level on the strobe pin selects one of two bus personalities with separate strobes, and the strap pin plays no part in that choice. The first transition in either direction on the strobe pin commits the device to one of two other personalities. The strap pin decides which one: the multiplexed address/data bus or the serial control port. That commitment is sticky, and only a hardware reset clears it.

Both pins pass through the same multi-flop synchronizer, so the two stay aligned in time. After reset, a short warm-up stops the synchronizer's reset contents from being read as a transition. The chosen mode is presented as a registered two-bit code, as a registered one-hot vector, and with a registered flag that shows the choice is committed. Downstream protocol engines and their multiplexer use these outputs.

Top module: `bus_mode_detect`

## Requirements
- R1: While `rst` is high, at every clock edge the outputs return to code 0 (one-hot 4'b0001) with `locked` low, whatever the pins do.
- R2: With the strobe pin held low and no transition seen since reset, the code is 0 (non-multiplexed, separate read and write strobes) and `locked` is low, whatever the strap pin does.
- R3: With the strobe pin held high and no transition seen since reset, the code is 1 (read/write line plus data strobe) and `locked` is low, whatever the strap pin does.
- R4: A strobe transition seen while the strap pin is low sets code 2 (multiplexed address/data) and raises `locked`.
- R5: A strobe transition seen while the strap pin is high sets code 3 (serial control port) and raises `locked`.
- R6: A rising transition and a falling transition both commit. This includes a transition between the first and second clock edges after reset is released.
- R7: Once `locked` is high, further strobe transitions and strap changes leave the code unchanged.
- R8: Only `rst` clears `locked`. After reset, selection by the strobe level works again.
- R9: `mode_onehot` has exactly one bit set, at the index equal to `mode_code`.
- R10: A pin value sampled at a clock edge reaches the outputs at the SYNC_STAGES-th edge after it (edge 3 counting the sampling edge, with the default of 2 stages).
- R11: The strap value used for a commit is the one sampled at the same clock edge as the strobe transition, even when both pins change together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| strobe_pin | input | 1 | Asynchronous strobe/clock pin; its level or its first transition picks the mode |
| strap_pin | input | 1 | Asynchronous strap pin; picks multiplexed (0) or serial (1) at commit |
| mode_code | output | 2 | Active mode: 0 split strobes, 1 read/write plus strobe, 2 multiplexed, 3 serial |
| mode_onehot | output | 4 | One-hot form of `mode_code` |
| locked | output | 1 | High once a transition has committed the mode |

## Verification
Two functions can land in the same cycle: edge detection on the strobe pin and the capture of the strap value. The bench provokes this by changing both pins on the same falling clock edge. The strap moves from 0 to 1 just as the strobe makes its first transition. The bench then expects the serial code, which shows that the strap value taken is the one aligned with the transition and not the stale one. A second collision, a transition in the warm-up window just after reset is released, is judged by expecting a commit rather than a missed edge.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    BM_SPLIT  = 2'd0,
    BM_RWSTB  = 2'd1,
    BM_MUXAD  = 2'd2,
    BM_SERIAL = 2'd3
  } bm_mode_e;

  localparam int BM_NUM_MODES = 4;
  localparam int BM_CODE_W    = $clog2(BM_NUM_MODES);
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bm_edge_lock.sv
module bm_edge_lock #(
  parameter int WARM = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_s,
  input  logic strap_s,
  output logic locked_q,
  output logic serial_q,
  output logic lock_next,
  output logic serial_next
);
  localparam int CW = $clog2(WARM + 1);

  logic [CW-1:0] warm_cnt;
  logic          primed;
  logic          prev_strobe;
  logic          edge_seen;
  logic          take;

  assign primed    = (warm_cnt == CW'(WARM));
  assign edge_seen = primed & (strobe_s ^ prev_strobe);
  assign take      = edge_seen & ~locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm_cnt    <= '0;
      prev_strobe <= 1'b0;
    end else begin
      prev_strobe <= strobe_s;
      if (!primed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign lock_next   = locked_q | take;
  assign serial_next = take ? strap_s : serial_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      serial_q <= 1'b0;
    end else begin
      locked_q <= lock_next;
      serial_q <= serial_next;
    end
  end

  // R6
  lock_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> locked_q);
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
  // R7
  serial_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> $stable(serial_q));
endmodule

// File: rtl/bm_mode_out.sv
module bm_mode_out
  import bm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lock_next,
  input  logic                    serial_next,
  input  logic                    level,
  output logic [BM_CODE_W-1:0]    mode_code,
  output logic [BM_NUM_MODES-1:0] mode_onehot
);
  bm_mode_e                code_d;
  logic [BM_NUM_MODES-1:0] onehot_d;

  always_comb begin
    if (lock_next) code_d = serial_next ? BM_SERIAL : BM_MUXAD;
    else           code_d = level ? BM_RWSTB : BM_SPLIT;
  end

  for (genvar m = 0; m < BM_NUM_MODES; m++) begin : g_hot
    assign onehot_d[m] = (code_d == bm_mode_e'(m));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_code   <= BM_SPLIT;
      mode_onehot <= BM_NUM_MODES'(1);
    end else begin
      mode_code   <= code_d;
      mode_onehot <= onehot_d;
    end
  end

  // R9
  onehot_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_onehot) == 1);
  // R9
  onehot_index_chk: assert property (@(posedge clk) disable iff (rst)
    mode_onehot[mode_code]);
endmodule

// File: rtl/bus_mode_detect.sv
module bus_mode_detect
  import bm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strobe_pin,
  input  logic                    strap_pin,
  output logic [BM_CODE_W-1:0]    mode_code,
  output logic [BM_NUM_MODES-1:0] mode_onehot,
  output logic                    locked
);
  localparam int WARM = SYNC_STAGES + 1;

  logic [1:0] pins_s;
  logic       lock_next;
  logic       serial_next;
  logic       serial_q;

  bm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({strap_pin, strobe_pin}),
    .dout (pins_s)
  );

  bm_edge_lock #(.WARM(WARM)) u_lock (
    .clk         (clk),
    .rst         (rst),
    .strobe_s    (pins_s[0]),
    .strap_s     (pins_s[1]),
    .locked_q    (locked),
    .serial_q    (serial_q),
    .lock_next   (lock_next),
    .serial_next (serial_next)
  );

  bm_mode_out u_out (
    .clk         (clk),
    .rst         (rst),
    .lock_next   (lock_next),
    .serial_next (serial_next),
    .level       (pins_s[0]),
    .mode_code   (mode_code),
    .mode_onehot (mode_onehot)
  );

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(mode_code));
  // R4
  locked_mode_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> mode_code[1]);
  // R2
  unlocked_level_chk: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !mode_code[1]);
  // R5
  serial_code_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (mode_code[0] == serial_q));
endmodule

// File: tb/test_bus_mode_detect.sv
module test_bus_mode_detect;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;

  typedef struct {
    logic [1:0] code;
    logic       lck;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_pin = 1'b0;
  logic       strap_pin = 1'b0;
  logic [1:0] mode_code;
  logic [3:0] mode_onehot;
  logic       locked;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_mode_detect i_bus_mode_detect (
    .clk         (clk),
    .rst         (rst),
    .strobe_pin  (strobe_pin),
    .strap_pin   (strap_pin),
    .mode_code   (mode_code),
    .mode_onehot (mode_onehot),
    .locked      (locked)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (mode_code !== e.code || locked !== e.lck ||
          mode_onehot !== (4'b0001 << e.code)) begin
        errors++;
        $display("FAIL %s: code=%0d locked=%0b onehot=%b, expected code=%0d locked=%0b onehot=%b",
                 e.tag, mode_code, locked, mode_onehot, e.code, e.lck, 4'b0001 << e.code);
      end
    end
  end

  task automatic expect_now(input logic [1:0] c, input logic l, input string t);
    exp_t e;
    e.code = c; e.lck = l; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic sb, input logic sp);
    @(negedge clk);
    rst = 1'b1; strobe_pin = sb; strap_pin = sp;
    edges(2);
    expect_now(2'd0, 1'b0, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic sb, input logic sp);
    @(negedge clk);
    strobe_pin = sb; strap_pin = sp;
  endtask

  initial begin
    // R1, R3: static high after reset
    do_reset(1'b1, 1'b0);
    edges(5);
    expect_now(2'd1, 1'b0, "R3 static high");
    drive(1'b1, 1'b1);
    edges(LAT + 1);
    expect_now(2'd1, 1'b0, "R3 strap ignored");
    drive(1'b1, 1'b0);
    edges(LAT + 1);
    expect_now(2'd1, 1'b0, "R3 strap ignored again");

    // R2: static low, strap toggles
    do_reset(1'b0, 1'b1);
    edges(5);
    expect_now(2'd0, 1'b0, "R2 static low");
    drive(1'b0, 1'b0);
    edges(LAT + 1);
    expect_now(2'd0, 1'b0, "R2 strap ignored");

    // R10, R4: rising edge with strap low, exact latency
    drive(1'b1, 1'b0);
    edges(LAT - 1);
    expect_now(2'd0, 1'b0, "R10 not yet visible");
    edges(1);
    expect_now(2'd2, 1'b1, "R10 R4 commit multiplexed");

    // R7: further edges and strap changes
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b1);
    edges(LAT + 2);
    expect_now(2'd2, 1'b1, "R7 held after activity");

    // R8, R5, R6: reset restores level mode, falling edge commits serial
    do_reset(1'b1, 1'b1);
    edges(5);
    expect_now(2'd1, 1'b0, "R8 level selection after reset");
    drive(1'b0, 1'b1);
    edges(LAT);
    expect_now(2'd3, 1'b1, "R5 R6 falling edge commits serial");
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    edges(LAT + 2);
    expect_now(2'd3, 1'b1, "R7 serial held");

    // R11: strobe and strap change on the same edge
    do_reset(1'b0, 1'b0);
    edges(5);
    expect_now(2'd0, 1'b0, "R2 before collision");
    drive(1'b1, 1'b1);
    edges(LAT);
    expect_now(2'd3, 1'b1, "R11 aligned strap capture");

    // R6: transition just after reset release
    do_reset(1'b0, 1'b0);
    edges(1);
    @(negedge clk);
    strobe_pin = 1'b1;
    edges(LAT + 3);
    expect_now(2'd2, 1'b1, "R6 early transition commits");

    // R1: reset with strobe toggling
    @(negedge clk);
    rst = 1'b1;
    strobe_pin = 1'b0;
    edges(1);
    expect_now(2'd0, 1'b0, "R1 reset while toggling");
    @(negedge clk);
    strobe_pin = 1'b1;
    edges(1);
    expect_now(2'd0, 1'b0, "R1 reset holds");
    @(negedge clk);
    rst = 1'b0;

    edges(2);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule